// File: doc/BRIEF.md
# Opcode Skip, No-op and Halt Sequencer

This block sits beside the fetch stage of a small 8-bit processor and takes over the opcode bytes that fall outside the standard instruction set. When the fetch stage presents an opcode together with its address and the current index register, the block sorts it into one of four groups: a single-byte no-op, a skip of one operand byte, a skip of two operand bytes, or a halt. It then runs the bus cycles that the opcode would really perform. These include operand fetches, zero-page reads, indexed reads and a page-crossing fix-up read. Every value read is thrown away.

When a skip or no-op finishes, the block pulses `done` for one cycle and reports two things: the total cycle count, which includes the opcode fetch cycle, and the advanced program counter. The normal decoder then takes over again. A halt opcode moves the block into a locked state. In that state it issues no further bus reads, accepts no further opcodes and grants no interrupts. Only a reset releases it.

Top module: `opskip_seq`

## Requirements
- R1: `claim` is high in a cycle only when `start` is high, the block is idle and not halted, and `opcode` is one of 1A 3A 5A 7A DA FA, 80 82 89 C2 E2, 04 14 34 44 54 64 74 D4 F4, 0C 1C 3C 5C 7C DC FC, 02 12 22 32 42 52 62 72 92 B2 D2 F2. For any other opcode the block stays idle: no read and no `done`.
- R2: The opcodes 1A, 3A, 5A, 7A, DA and FA perform one read at `pc_in+1`. They then report 2 cycles, and `pc_out` becomes `pc_in+1`.
- R3: The opcodes 80, 82, 89, C2 and E2 read the operand at `pc_in+1`. They then report 2 cycles, and `pc_out` becomes `pc_in+2`.
- R4: The opcodes 04, 44 and 64 read the operand byte B at `pc_in+1` and then read address 00B. They report 3 cycles, and `pc_out` becomes `pc_in+2`.
- R5: The opcodes 14, 34, 54, 74, D4 and F4 read the operand byte B, then make a dummy read at 00B, then read at 00 followed by the byte (B+X) mod 256. They report 4 cycles, and `pc_out` becomes `pc_in+2`.
- R6: Opcode 0C reads the low byte L at `pc_in+1` and the high byte H at `pc_in+2`, then reads address HL. It reports 4 cycles, and `pc_out` becomes `pc_in+3`.
- R7: The opcodes 1C, 3C, 5C, 7C, DC and FC read L and H, then read address H followed by the byte (L+X) mod 256. If L+X exceeds 255, a fifth cycle reads the full 16-bit sum HL+X, and the opcode reports 5 cycles instead of 4. `pc_out` becomes `pc_in+3`.
- R8: `done` stays high for exactly one cycle, in the cycle after the last read. `done_cycles` in that cycle carries the count. The data that was read has no effect on `pc_out`.
- R9: A halt opcode raises `halted` in the next cycle, with `pc_out` equal to `pc_in+1`. While halted, the block makes no reads, accepts no opcode and keeps `pc_out` unchanged. Only a reset clears the halted state.
- R10: `int_grant` follows `int_req` while the block is idle and not halted. While the block is halted, `int_grant` is always low.
- R11: After reset, the outputs `halted`, `done`, `mem_rd`, `busy` and `pc_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opcode byte valid this cycle |
| opcode | input | 8 | Fetched opcode |
| pc_in | input | 16 | Address of the fetched opcode |
| x_in | input | 8 | Index register value |
| int_req | input | 1 | Pending interrupt |
| mem_data | input | 8 | Read data, same cycle as `mem_rd` |
| claim | output | 1 | Opcode taken by this block |
| busy | output | 1 | Sequence in progress |
| mem_rd | output | 1 | Dummy read strobe |
| mem_addr | output | 16 | Read address |
| done | output | 1 | One-cycle end-of-sequence pulse |
| done_cycles | output | 3 | Total cycles of the finished opcode |
| pc_out | output | 16 | Program counter held by the block |
| halted | output | 1 | Locked by a halt opcode |
| int_grant | output | 1 | Interrupt may be taken |

## Verification
The case that is hardest to reach is the fifth-cycle fix-up read of the indexed two-byte skip. It happens only when the operand low byte, which the memory itself returns, plus X carries out of the page. The bench's memory returns a known function of the address, and each opcode is run with X set to 00, FF and the opcode value. This means every indexed form is exercised both with and without a carry, and the zero-page index also wraps. The halt lock can only be left through reset, so every halt opcode is followed by probes of start, interrupts and the bus, and then by a reset.

// File: rtl/opskip_pkg.sv
package opskip_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_NOP,
        CLS_SKB_IMM,
        CLS_SKB_ZP,
        CLS_SKB_ZPX,
        CLS_SKW_ABS,
        CLS_SKW_ABX,
        CLS_HALT
    } op_cls_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OP1,
        ST_OP2,
        ST_ZP,
        ST_ZPX,
        ST_EA,
        ST_FIX,
        ST_HALT
    } seq_st_e;

    typedef enum logic [2:0] {
        AS_PC1,
        AS_PC2,
        AS_ZP,
        AS_ZPX,
        AS_EA,
        AS_FIX
    } addr_sel_e;

endpackage

// File: rtl/opskip_classify.sv
module opskip_classify
    import opskip_pkg::*;
(
    input  logic [7:0] op,
    output op_cls_e    cls
);
    logic [3:0] hi_n;
    logic [3:0] lo_n;
    logic       odd_col;

    assign hi_n    = op[7:4];
    assign lo_n    = op[3:0];
    // odd high nibbles except 9 and B: 1,3,5,7,D,F
    assign odd_col = hi_n[0] && (hi_n != 4'h9) && (hi_n != 4'hB);

    always_comb begin
        cls = CLS_NONE;
        unique case (lo_n)
            4'hA: if (odd_col) cls = CLS_NOP;
            4'h2: begin
                if (hi_n[0] || !hi_n[3])
                    cls = CLS_HALT;
                else if (hi_n != 4'hA)
                    cls = CLS_SKB_IMM;
            end
            4'h0: if (hi_n == 4'h8) cls = CLS_SKB_IMM;
            4'h9: if (hi_n == 4'h8) cls = CLS_SKB_IMM;
            4'h4: begin
                if (hi_n == 4'h0 || hi_n == 4'h4 || hi_n == 4'h6)
                    cls = CLS_SKB_ZP;
                else if (odd_col)
                    cls = CLS_SKB_ZPX;
            end
            4'hC: begin
                if (hi_n == 4'h0)
                    cls = CLS_SKW_ABS;
                else if (odd_col)
                    cls = CLS_SKW_ABX;
            end
            default: cls = CLS_NONE;
        endcase
    end
endmodule

// File: rtl/opskip_agen.sv
module opskip_agen
    import opskip_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  addr_sel_e       sel,
    input  logic [AW-1:0]   pc,
    input  logic [DW-1:0]   lo,
    input  logic [DW-1:0]   hi,
    input  logic [DW-1:0]   idx,
    output logic [AW-1:0]   addr,
    output logic            page_cy
);
    logic [DW:0]   sum_lo;
    logic [DW-1:0] hi_fix;

    assign sum_lo  = {1'b0, lo} + {1'b0, idx};
    assign page_cy = sum_lo[DW];
    assign hi_fix  = hi + {{(DW-1){1'b0}}, sum_lo[DW]};

    always_comb begin
        unique case (sel)
            AS_PC1:  addr = pc + AW'(1);
            AS_PC2:  addr = pc + AW'(2);
            AS_ZP:   addr = {{DW{1'b0}}, lo};
            AS_ZPX:  addr = {{DW{1'b0}}, sum_lo[DW-1:0]};
            AS_EA:   addr = {hi, sum_lo[DW-1:0]};
            AS_FIX:  addr = {hi_fix, sum_lo[DW-1:0]};
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/opskip_seq.sv
module opskip_seq
    import opskip_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 3,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] x_in,
    input  logic          int_req,
    input  logic [DW-1:0] mem_data,
    output logic          claim,
    output logic          busy,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [CW-1:0] done_cycles,
    output logic [AW-1:0] pc_out,
    output logic          halted,
    output logic          int_grant
);
    typedef struct packed {
        seq_st_e       st;
        op_cls_e       cls;
        logic [AW-1:0] pc;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [DW-1:0] x;
        logic [CW-1:0] cyc;
        logic          done;
        logic [CW-1:0] done_cyc;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    op_cls_e   cls_in;
    addr_sel_e sel;
    logic      page_cy;
    logic      idle;

    opskip_classify u_cls (
        .op  (opcode),
        .cls (cls_in)
    );

    opskip_agen #(.DW(DW)) u_agen (
        .sel     (sel),
        .pc      (r_q.pc),
        .lo      (r_q.lo),
        .hi      (r_q.hi),
        .idx     (r_q.x),
        .addr    (mem_addr),
        .page_cy (page_cy)
    );

    assign idle  = (r_q.st == ST_IDLE);
    assign claim = start && idle && (cls_in != CLS_NONE);

    always_comb begin
        unique case (r_q.st)
            ST_OP1:  sel = AS_PC1;
            ST_OP2:  sel = AS_PC2;
            ST_ZP:   sel = AS_ZP;
            ST_ZPX:  sel = AS_ZPX;
            ST_EA:   sel = AS_EA;
            ST_FIX:  sel = AS_FIX;
            default: sel = AS_PC1;
        endcase
    end

    always_comb begin
        logic          fin;
        logic [AW-1:0] len;
        r_d      = r_q;
        r_d.done = 1'b0;
        fin      = 1'b0;
        len      = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (claim) begin
                    r_d.cls = cls_in;
                    r_d.pc  = pc_in;
                    r_d.x   = (cls_in == CLS_SKW_ABS) ? '0 : x_in;
                    r_d.cyc = CW'(2);
                    if (cls_in == CLS_HALT) begin
                        r_d.st = ST_HALT;
                        r_d.pc = pc_in + AW'(1);
                    end else begin
                        r_d.st = ST_OP1;
                    end
                end
            end
            ST_OP1: begin
                r_d.lo = mem_data;
                unique case (r_q.cls)
                    CLS_NOP:     begin fin = 1'b1; len = AW'(1); end
                    CLS_SKB_IMM: begin fin = 1'b1; len = AW'(2); end
                    CLS_SKB_ZP, CLS_SKB_ZPX: r_d.st = ST_ZP;
                    default:     r_d.st = ST_OP2;
                endcase
            end
            ST_ZP: begin
                if (r_q.cls == CLS_SKB_ZPX) begin
                    r_d.st = ST_ZPX;
                end else begin
                    fin = 1'b1;
                    len = AW'(2);
                end
            end
            ST_ZPX: begin
                fin = 1'b1;
                len = AW'(2);
            end
            ST_OP2: begin
                r_d.hi = mem_data;
                r_d.st = ST_EA;
            end
            ST_EA: begin
                if (page_cy) begin
                    r_d.st = ST_FIX;
                end else begin
                    fin = 1'b1;
                    len = AW'(3);
                end
            end
            ST_FIX: begin
                fin = 1'b1;
                len = AW'(3);
            end
            ST_HALT: begin
                r_d.st = ST_HALT;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (fin) begin
            r_d.st       = ST_IDLE;
            r_d.done     = 1'b1;
            r_d.done_cyc = r_q.cyc;
            r_d.pc       = r_q.pc + len;
        end else if (r_q.st != ST_IDLE && r_q.st != ST_HALT) begin
            r_d.cyc = r_q.cyc + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cls: CLS_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign halted      = (r_q.st == ST_HALT);
    assign busy        = !idle && !halted;
    assign mem_rd      = busy;
    assign done        = r_q.done;
    assign done_cycles = r_q.done_cyc;
    assign pc_out      = r_q.pc;
    assign int_grant   = int_req && idle;

endmodule

// File: rtl/opskip_seq_chk.sv
module opskip_seq_chk #(
    parameter int DW = 8,
    parameter int CW = 3,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          claim,
    input logic          busy,
    input logic          mem_rd,
    input logic          done,
    input logic [CW-1:0] done_cycles,
    input logic [AW-1:0] pc_out,
    input logic          halted,
    input logic          int_grant
);
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_rd && !busy && !claim));

    p_halt_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_out));

    p_halt_no_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !int_grant);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_cycles >= CW'(2) && done_cycles <= CW'(5)));

    p_claim_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        claim |=> (busy || halted));

    p_busy_no_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !int_grant);
endmodule

bind opskip_seq opskip_seq_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim       (claim),
    .busy        (busy),
    .mem_rd      (mem_rd),
    .done        (done),
    .done_cycles (done_cycles),
    .pc_out      (pc_out),
    .halted      (halted),
    .int_grant   (int_grant)
);

// File: tb/opskip_seq_test.sv
module opskip_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  x_in = 8'h00;
    logic        int_req = 1'b0;
    logic [7:0]  mem_data;
    logic        claim, busy, mem_rd, done, halted, int_grant;
    logic [15:0] mem_addr, pc_out;
    logic [2:0]  done_cycles;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction

    assign mem_data = memf(mem_addr);

    opskip_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .pc_in(pc_in), .x_in(x_in), .int_req(int_req), .mem_data(mem_data),
        .claim(claim), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .done(done), .done_cycles(done_cycles), .pc_out(pc_out),
        .halted(halted), .int_grant(int_grant)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // 0 none, 1 nop, 2 imm, 3 zp, 4 zpx, 5 abs, 6 abx, 7 halt
    function automatic int bcls(input logic [7:0] op);
        case (op)
            8'h1A, 8'h3A, 8'h5A, 8'h7A, 8'hDA, 8'hFA: return 1;
            8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2: return 2;
            8'h04, 8'h44, 8'h64: return 3;
            8'h14, 8'h34, 8'h54, 8'h74, 8'hD4, 8'hF4: return 4;
            8'h0C: return 5;
            8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC, 8'hFC: return 6;
            8'h02, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52, 8'h62, 8'h72,
            8'h92, 8'hB2, 8'hD2, 8'hF2: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic string rtag(input int c);
        case (c)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [15:0] pc,
                          input logic [7:0] x);
        int c;
        logic [15:0] ea [0:4];
        int n_exp, cyc_exp, len, nrd;
        logic [7:0] lo, hi;
        logic [8:0] s;
        string rq;
        c  = bcls(op);
        lo = memf(pc + 16'd1);
        hi = memf(pc + 16'd2);
        s  = {1'b0, lo} + {1'b0, x};
        ea[0] = pc + 16'd1;
        ea[1] = 16'h0; ea[2] = 16'h0; ea[3] = 16'h0; ea[4] = 16'h0;
        n_exp = 1; cyc_exp = 2; len = 1;
        case (c)
            2: len = 2;
            3: begin ea[1] = {8'h00, lo}; n_exp = 2; cyc_exp = 3; len = 2; end
            4: begin
                ea[1] = {8'h00, lo}; ea[2] = {8'h00, s[7:0]};
                n_exp = 3; cyc_exp = 4; len = 2;
            end
            5: begin
                ea[1] = pc + 16'd2; ea[2] = {hi, lo};
                n_exp = 3; cyc_exp = 4; len = 3;
            end
            6: begin
                ea[1] = pc + 16'd2; ea[2] = {hi, s[7:0]};
                n_exp = 3; cyc_exp = 4; len = 3;
                if (s[8]) begin
                    ea[3] = {hi, lo} + {8'h00, x};
                    n_exp = 4; cyc_exp = 5;
                end
            end
            default: ;
        endcase
        rq = rtag(c);

        @(negedge clk);
        start = 1'b1; opcode = op; pc_in = pc; x_in = x;
        #1;
        chk(claim == (c != 0), "R1", $sformatf("claim op %h", op), claim, c != 0);
        @(negedge clk);
        start = 1'b0;

        if (c == 0) begin
            chk(!busy && !mem_rd && !done, "R1", $sformatf("idle op %h", op),
                {busy, mem_rd, done}, 0);
            return;
        end

        if (c == 7) begin
            chk(halted, "R9", $sformatf("halted op %h", op), halted, 1);
            chk(pc_out == pc + 16'd1, "R9", "halt pc", pc_out, pc + 16'd1);
            chk(!mem_rd, "R9", "halt no read", mem_rd, 0);
            int_req = 1'b1; #1;
            chk(!int_grant, "R10", "grant while halted", int_grant, 0);
            @(negedge clk);
            start = 1'b1; opcode = 8'h1A; #1;
            chk(!claim, "R9", "start ignored while halted", claim, 0);
            @(negedge clk);
            start = 1'b0;
            chk(halted && !mem_rd && !done && pc_out == pc + 16'd1, "R9",
                "still locked", {halted, mem_rd, done}, 3'b100);
            int_req = 1'b0;
            rst_n = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            chk(!halted, "R9", "reset clears halt", halted, 0);
            return;
        end

        nrd = 0;
        for (int k = 0; k < 8; k++) begin
            if (done) break;
            if (mem_rd) begin
                if (nrd < 5)
                    chk(mem_addr == ea[nrd], rq,
                        $sformatf("op %h read %0d addr", op, nrd), mem_addr, ea[nrd]);
                nrd++;
            end
            @(negedge clk);
        end
        chk(done, "R8", $sformatf("done op %h", op), done, 1);
        chk(nrd == n_exp, rq, $sformatf("op %h read count", op), nrd, n_exp);
        chk(done_cycles == 3'(cyc_exp), rq, $sformatf("op %h cycles x=%h", op, x),
            done_cycles, cyc_exp);
        chk(pc_out == pc + 16'(len), rq, $sformatf("op %h pc", op), pc_out,
            pc + 16'(len));
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
    endtask

    initial begin
        #50000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk(!halted && !done && !mem_rd && !busy && pc_out == 16'h0, "R11",
            "reset state", {halted, done, mem_rd, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        int_req = 1'b1; #1;
        chk(int_grant, "R10", "grant when idle", int_grant, 1);
        int_req = 1'b0;
        for (int op = 0; op < 256; op++) begin
            for (int v = 0; v < 3; v++) begin
                logic [7:0] xv;
                xv = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : 8'(op);
                run_op(8'(op), {8'(op * 3 + v), 8'(op ^ 8'hA5)}, xv);
            end
        end
        // page edge of the program counter itself
        run_op(8'h0C, 16'hFFFE, 8'h00);
        run_op(8'hFC, 16'h12FE, 8'h80);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule